// File: doc/BRIEF.md
# Packet DRAM Command Timing Checker

This block sits beside the command path of one packet-based DRAM device and watches every command sent to it. Row packets (activate, row precharge) and column packets (read, write, retire, byte mask) arrive as a strobe with a command code and a bank number. The checker keeps saturating cycle counters for each bank and for the whole device. It flags any command that comes earlier than the spacing rules allow, and it also flags column access to a closed bank and activation of a bank that is already open. One speed-grade input selects the activate-to-column delay.

Each bank runs a two-state machine with the states BK_CLOSED and BK_OPEN. The transition OPEN_ON_ACT moves BK_CLOSED to BK_OPEN on an activate. The transition CLOSE_ON_PRE moves BK_OPEN to BK_CLOSED on a row precharge. Any other command leaves the state unchanged. The sticky error flag is a second machine with the states ERR_CLEAR and ERR_SET. The transition RAISE moves it to ERR_SET on any violation, and RAISE has priority. The transition LOWER moves it back to ERR_CLEAR on a synchronous clear that arrives with no violation.

A command still updates the counters and the bank state when it breaks a rule. The checker therefore tracks what the device actually received.

Top module: `dtc_checker`

## Requirements
- R1: Reset treats every counter as expired. During reset and directly after it, `viol` is 0 and `err_sticky` is 0, and the first command raises no violation. Command codes: 0 none, 1 activate, 2 row precharge, 3 read, 4 write, 5 retire, 6 byte mask, 7 reserved.
- R2: Bit 0 (row cycle) is raised by an activate that comes less than 28 cycles after the previous activate to the same bank.
- R3: Bit 1 (row active) is raised by a row precharge that comes less than 20 cycles after the last activate to the same bank.
- R4: Bit 2 (row precharge) is raised by an activate that comes less than 8 cycles after the last row precharge to the same bank.
- R5: Across the whole device, bit 3 is raised by an activate that comes less than 8 cycles after any activate. Bit 4 is raised by a row precharge that comes less than 8 cycles after any row precharge.
- R6: Bit 5 is raised by a read or write that comes too soon after the activate of its bank. The minimum is 9 cycles when `grade_fast` is 1 and 7 cycles when it is 0.
- R7: Bit 6 is raised by a column command (read, write, retire, byte mask) that comes less than 4 cycles after the previous column command to the device.
- R8: Bit 7 is raised by a retire or byte mask that comes less than 8 cycles after the last write to the device.
- R9: A row precharge raises bit 8 when it comes less than 4 cycles after the last read to its bank. It raises bit 9 when it comes less than 4 cycles after the last retire to its bank.
- R10: Bit 10 is raised by a read or write to a closed bank. Bit 11 is raised by an activate to an open bank. A row precharge to a closed bank raises neither bit.
- R11: A command at clock edge t shows its violations in `viol` for exactly the one cycle after t. With `cmd_valid` low, or with the reserved code, nothing is checked and no state changes.
- R12: `err_sticky` sets in the same cycle as any `viol` bit and drops one cycle after `clr`. A violation in the same cycle as `clr` keeps the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr | input | 1 | Synchronous clear of the sticky flag |
| cmd_valid | input | 1 | Command strobe |
| cmd_type | input | 3 | Command code (see R1) |
| cmd_bank | input | 5 | Target bank |
| grade_fast | input | 1 | 1 selects the fast speed grade |
| viol | output | 12 | One-cycle violation pulse, one bit per rule |
| err_sticky | output | 1 | Sticky error flag |

## Verification
A violating command and a sticky clear can land in the same clock cycle. The flag's set and lower transitions then compete. The bench provokes this by driving `clr` together with an activate that breaks both the row-cycle rule and the row-precharge rule. It expects both violation bits to pulse and the flag to stay set. The bench has already lowered the flag with a clear alone in the cycle before, and it lowers it again with a clear alone in the cycle after, so the outcome cannot come from a flag that was never cleared.

// File: rtl/dtc_pkg.sv
`timescale 1ns/1ps
package dtc_pkg;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_PRE = 3'd2,
        CMD_RD  = 3'd3,
        CMD_WR  = 3'd4,
        CMD_RET = 3'd5,
        CMD_MSK = 3'd6,
        CMD_RSV = 3'd7
    } cmd_e;

    localparam int NUM_RULES = 12;

    localparam int V_RC     = 0;
    localparam int V_RAS    = 1;
    localparam int V_RP     = 2;
    localparam int V_RR     = 3;
    localparam int V_PP     = 4;
    localparam int V_RCD    = 5;
    localparam int V_CC     = 6;
    localparam int V_RTR    = 7;
    localparam int V_RDP    = 8;
    localparam int V_RTP    = 9;
    localparam int V_CLOSED = 10;
    localparam int V_REOPEN = 11;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dtc_satcnt.sv
`timescale 1ns/1ps
module dtc_satcnt #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] TOP = '1;

    // Counts cycles since the last restart and holds at TOP.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= TOP;
        end else if (restart) begin
            cnt <= W'(1);
        end else if (cnt != TOP) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R1: the counter starts expired and never wraps to zero
    assert_cnt_nonzero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt != '0);

endmodule

// File: rtl/dtc_bank.sv
`timescale 1ns/1ps
module dtc_bank
    import dtc_pkg::*;
#(
    parameter int CW         = 5,
    parameter int T_RC       = 28,
    parameter int T_RAS      = 20,
    parameter int T_RP       = 8,
    parameter int T_RCD_FAST = 9,
    parameter int T_RCD_SLOW = 7,
    parameter int T_RDP      = 4,
    parameter int T_RTP      = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sel,
    input  cmd_e                 cmd,
    input  logic                 fast,
    output logic [NUM_RULES-1:0] viol
);
    typedef enum logic {BK_CLOSED = 1'b0, BK_OPEN = 1'b1} bank_st_e;

    bank_st_e state_q, state_d;

    logic is_act, is_pre, is_rd, is_wr, is_ret;
    logic [CW-1:0] act_cnt, pre_cnt, rd_cnt, ret_cnt;
    logic [CW-1:0] rcd_min;

    assign is_act = sel && (cmd == CMD_ACT);
    assign is_pre = sel && (cmd == CMD_PRE);
    assign is_rd  = sel && (cmd == CMD_RD);
    assign is_wr  = sel && (cmd == CMD_WR);
    assign is_ret = sel && (cmd == CMD_RET);

    assign rcd_min = fast ? CW'(T_RCD_FAST) : CW'(T_RCD_SLOW);

    dtc_satcnt #(.W(CW)) u_act_cnt (.clk(clk), .rst_n(rst_n), .restart(is_act), .cnt(act_cnt));
    dtc_satcnt #(.W(CW)) u_pre_cnt (.clk(clk), .rst_n(rst_n), .restart(is_pre), .cnt(pre_cnt));
    dtc_satcnt #(.W(CW)) u_rd_cnt  (.clk(clk), .rst_n(rst_n), .restart(is_rd),  .cnt(rd_cnt));
    dtc_satcnt #(.W(CW)) u_ret_cnt (.clk(clk), .rst_n(rst_n), .restart(is_ret), .cnt(ret_cnt));

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= BK_CLOSED;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: OPEN_ON_ACT and CLOSE_ON_PRE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BK_CLOSED: if (is_act) state_d = BK_OPEN;
            BK_OPEN:   if (is_pre) state_d = BK_CLOSED;
        endcase
    end

    // Outputs: per-bank rule checks against the counters as they stand
    always_comb begin
        viol = '0;
        if (is_act) begin
            viol[V_RC]     = act_cnt < CW'(T_RC);
            viol[V_RP]     = pre_cnt < CW'(T_RP);
            viol[V_REOPEN] = (state_q == BK_OPEN);
        end
        if (is_pre) begin
            viol[V_RAS] = act_cnt < CW'(T_RAS);
            viol[V_RDP] = rd_cnt  < CW'(T_RDP);
            viol[V_RTP] = ret_cnt < CW'(T_RTP);
        end
        if (is_rd || is_wr) begin
            viol[V_RCD]    = act_cnt < rcd_min;
            viol[V_CLOSED] = (state_q == BK_CLOSED);
        end
    end

    // R10: an activate always leaves the bank open
    assert_open_on_act_R10: assert property (@(posedge clk) disable iff (!rst_n)
        is_act |=> (state_q == BK_OPEN));

    // R10: a row precharge always leaves the bank closed
    assert_close_on_pre_R10: assert property (@(posedge clk) disable iff (!rst_n)
        is_pre |=> (state_q == BK_CLOSED));

endmodule

// File: rtl/dtc_device.sv
`timescale 1ns/1ps
module dtc_device
    import dtc_pkg::*;
#(
    parameter int CW    = 5,
    parameter int T_RR  = 8,
    parameter int T_PP  = 8,
    parameter int T_CC  = 4,
    parameter int T_RTR = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 valid,
    input  cmd_e                 cmd,
    output logic [NUM_RULES-1:0] viol
);
    logic is_act, is_pre, is_col, is_wr, is_late_col;
    logic [CW-1:0] act_cnt, pre_cnt, col_cnt, wr_cnt;

    assign is_act      = valid && (cmd == CMD_ACT);
    assign is_pre      = valid && (cmd == CMD_PRE);
    assign is_wr       = valid && (cmd == CMD_WR);
    assign is_late_col = valid && ((cmd == CMD_RET) || (cmd == CMD_MSK));
    assign is_col      = valid && ((cmd == CMD_RD) || (cmd == CMD_WR) ||
                                   (cmd == CMD_RET) || (cmd == CMD_MSK));

    dtc_satcnt #(.W(CW)) u_act_cnt (.clk(clk), .rst_n(rst_n), .restart(is_act), .cnt(act_cnt));
    dtc_satcnt #(.W(CW)) u_pre_cnt (.clk(clk), .rst_n(rst_n), .restart(is_pre), .cnt(pre_cnt));
    dtc_satcnt #(.W(CW)) u_col_cnt (.clk(clk), .rst_n(rst_n), .restart(is_col), .cnt(col_cnt));
    dtc_satcnt #(.W(CW)) u_wr_cnt  (.clk(clk), .rst_n(rst_n), .restart(is_wr),  .cnt(wr_cnt));

    always_comb begin
        viol = '0;
        viol[V_RR]  = is_act      && (act_cnt < CW'(T_RR));
        viol[V_PP]  = is_pre      && (pre_cnt < CW'(T_PP));
        viol[V_CC]  = is_col      && (col_cnt < CW'(T_CC));
        viol[V_RTR] = is_late_col && (wr_cnt  < CW'(T_RTR));
    end

    // R7: after a column command the column counter restarts from one
    assert_col_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        is_col |=> (col_cnt == CW'(1)));

endmodule

// File: rtl/dtc_checker.sv
`timescale 1ns/1ps
module dtc_checker
    import dtc_pkg::*;
#(
    parameter int NUM_BANKS  = 32,
    parameter int T_RC       = 28,
    parameter int T_RAS      = 20,
    parameter int T_RP       = 8,
    parameter int T_RR       = 8,
    parameter int T_PP       = 8,
    parameter int T_RCD_FAST = 9,
    parameter int T_RCD_SLOW = 7,
    parameter int T_CC       = 4,
    parameter int T_RTR      = 8,
    parameter int T_RDP      = 4,
    parameter int T_RTP      = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr,
    input  logic                         cmd_valid,
    input  logic [2:0]                   cmd_type,
    input  logic [$clog2(NUM_BANKS)-1:0] cmd_bank,
    input  logic                         grade_fast,
    output logic [NUM_RULES-1:0]         viol,
    output logic                         err_sticky
);
    localparam int BANK_W = $clog2(NUM_BANKS);
    localparam int T_MAX  = max2(max2(max2(T_RC, T_RAS), max2(T_RP, T_RR)),
                                 max2(max2(T_PP, max2(T_RCD_FAST, T_RCD_SLOW)),
                                      max2(max2(T_CC, T_RTR), max2(T_RDP, T_RTP))));
    localparam int CW     = $clog2(T_MAX + 1);

    typedef enum logic {ERR_CLEAR = 1'b0, ERR_SET = 1'b1} err_st_e;

    cmd_e                 cmd;
    logic [NUM_RULES-1:0] bank_viol [NUM_BANKS];
    logic [NUM_RULES-1:0] any_bank_viol;
    logic [NUM_RULES-1:0] dev_viol;
    logic [NUM_RULES-1:0] viol_d;
    err_st_e              err_q, err_d;

    assign cmd = cmd_e'(cmd_type);

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        logic sel;
        assign sel = cmd_valid && (cmd_bank == BANK_W'(g));
        dtc_bank #(
            .CW(CW), .T_RC(T_RC), .T_RAS(T_RAS), .T_RP(T_RP),
            .T_RCD_FAST(T_RCD_FAST), .T_RCD_SLOW(T_RCD_SLOW),
            .T_RDP(T_RDP), .T_RTP(T_RTP)
        ) u_bank (
            .clk(clk), .rst_n(rst_n), .sel(sel), .cmd(cmd),
            .fast(grade_fast), .viol(bank_viol[g])
        );
    end

    dtc_device #(
        .CW(CW), .T_RR(T_RR), .T_PP(T_PP), .T_CC(T_CC), .T_RTR(T_RTR)
    ) u_device (
        .clk(clk), .rst_n(rst_n), .valid(cmd_valid), .cmd(cmd), .viol(dev_viol)
    );

    always_comb begin
        any_bank_viol = '0;
        for (int i = 0; i < NUM_BANKS; i++) begin
            any_bank_viol = any_bank_viol | bank_viol[i];
        end
    end

    assign viol_d = any_bank_viol | dev_viol;

    // Pulse register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            viol <= '0;
        end else begin
            viol <= viol_d;
        end
    end

    // Sticky flag state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= ERR_CLEAR;
        end else begin
            err_q <= err_d;
        end
    end

    // Sticky flag next state: RAISE wins over LOWER
    always_comb begin
        err_d = err_q;
        unique case (err_q)
            ERR_CLEAR: if (|viol_d) err_d = ERR_SET;
            ERR_SET:   if (clr && !(|viol_d)) err_d = ERR_CLEAR;
        endcase
    end

    assign err_sticky = (err_q == ERR_SET);

    // R11: a pulse only follows a valid command
    assert_pulse_after_cmd_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (|viol) |-> $past(cmd_valid));

    // R12: every pulse is mirrored by the sticky flag
    assert_sticky_follows_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (|viol) |-> err_sticky);

    // R12: after a clear the flag is low unless a new pulse arrived
    assert_clear_lowers_R12: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!err_sticky || (|viol)));

endmodule

// File: tb/dtc_checker_bench.sv
`timescale 1ns/1ps
module dtc_checker_bench;

    localparam logic [11:0] B_RC = 12'h001, B_RAS = 12'h002, B_RP = 12'h004,
                            B_RR = 12'h008, B_PP = 12'h010, B_RCD = 12'h020,
                            B_CC = 12'h040, B_RTR = 12'h080, B_RDP = 12'h100,
                            B_RTP = 12'h200, B_CLS = 12'h400, B_OPN = 12'h800;
    localparam logic [2:0] C_NOP = 3'd0, C_ACT = 3'd1, C_PRE = 3'd2, C_RD = 3'd3,
                           C_WR = 3'd4, C_RET = 3'd5, C_MSK = 3'd6, C_RSV = 3'd7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_type = 3'd0;
    logic [4:0]  cmd_bank = 5'd0;
    logic        grade_fast = 1'b1;
    logic [11:0] viol;
    logic        err_sticky;

    typedef struct {
        logic [11:0] v;
        logic        e;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    logic err_m = 1'b0;
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    dtc_checker u_dtc_checker (
        .clk(clk), .rst_n(rst_n), .clr(clr), .cmd_valid(cmd_valid),
        .cmd_type(cmd_type), .cmd_bank(cmd_bank), .grade_fast(grade_fast),
        .viol(viol), .err_sticky(err_sticky)
    );

    // Driver: one cycle per call, pushes the expected result
    task automatic step(input logic vld, input logic [2:0] typ, input int bank,
                        input logic [11:0] ev, input logic c, input string tag);
        exp_t x;
        @(negedge clk);
        cmd_valid = vld;
        cmd_type  = typ;
        cmd_bank  = bank[4:0];
        clr       = c;
        if (ev != 12'h000) err_m = 1'b1;
        else if (c)        err_m = 1'b0;
        x.v = ev; x.e = err_m; x.tag = tag;
        q.push_back(x);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, C_NOP, 0, 12'h000, 1'b0, "R11 idle");
    endtask

    // Monitor: compares one cycle after each driven cycle
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t x;
                x = q.pop_front();
                checks++;
                if (viol !== x.v) begin
                    errors++;
                    $display("FAIL %s viol actual=%h expected=%h", x.tag, viol, x.v);
                end
                checks++;
                if (err_sticky !== x.e) begin
                    errors++;
                    $display("FAIL %s err_sticky actual=%b expected=%b", x.tag, err_sticky, x.e);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R11 watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (viol !== 12'h000 || err_sticky !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset actual=%h/%b expected=000/0", viol, err_sticky);
        end
        rst_n = 1'b1;
        idle(3);
        // fast grade, t0
        step(1'b1, C_ACT, 0, 12'h000, 1'b0, "R1 first command");
        idle(6);
        step(1'b1, C_ACT, 1, B_RR, 1'b0, "R5 act-act device");
        step(1'b1, C_RD, 0, B_RCD, 1'b0, "R6 fast grade delay");
        idle(2);
        step(1'b1, C_WR, 0, B_CC, 1'b0, "R7 column spacing");
        idle(3);
        step(1'b1, C_RET, 0, B_RTR, 1'b0, "R8 retire after write");
        idle(1);
        step(1'b1, C_PRE, 0, B_RAS | B_RTP, 1'b0, "R3 R9 early precharge");
        idle(4);
        step(1'b1, C_ACT, 0, B_RC | B_RP, 1'b0, "R2 R4 early reactivate");
        idle(3);
        step(1'b1, C_RD, 2, B_CLS, 1'b0, "R10 read closed bank");
        idle(3);
        step(1'b1, C_ACT, 1, B_RC | B_OPN, 1'b0, "R10 R2 activate open bank");
        step(1'b1, C_PRE, 2, 12'h000, 1'b0, "R10 precharge closed bank");
        idle(1);
        step(1'b1, C_PRE, 3, B_PP, 1'b0, "R5 pre-pre device");
        // slow grade, s
        @(negedge clk);
        grade_fast = 1'b0;
        idle(40);
        step(1'b1, C_ACT, 5, 12'h000, 1'b0, "R6 slow activate");
        idle(6);
        step(1'b1, C_RD, 5, 12'h000, 1'b0, "R6 slow grade exact");
        step(1'b1, C_ACT, 6, 12'h000, 1'b0, "R5 act-act exact");
        idle(5);
        step(1'b1, C_WR, 6, B_RCD, 1'b0, "R6 slow grade early");
        idle(3);
        step(1'b1, C_RD, 5, 12'h000, 1'b0, "R7 column exact");
        idle(1);
        step(1'b1, C_PRE, 5, B_RDP, 1'b0, "R9 precharge after read");
        idle(1);
        step(1'b1, C_MSK, 0, 12'h000, 1'b0, "R8 mask exact");
        step(1'b1, C_MSK, 0, B_CC, 1'b0, "R7 mask spacing");
        step(1'b0, C_ACT, 5, 12'h000, 1'b0, "R11 strobe low");
        step(1'b1, C_RSV, 5, 12'h000, 1'b0, "R11 reserved code");
        step(1'b0, C_NOP, 0, 12'h000, 1'b1, "R12 clear alone");
        step(1'b1, C_ACT, 5, B_RC | B_RP, 1'b1, "R12 clear with violation");
        step(1'b0, C_NOP, 0, 12'h000, 1'b1, "R12 clear again");
        idle(2);
        @(negedge clk);
        cmd_valid = 1'b0;
        clr = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule